// File: doc/BRIEF.md
# Indirect interrupt redirection register file

This block holds the programmable routing state of an interrupt controller: one 64-bit redirection entry per interrupt pin (24 by default), a 4-bit controller identifier and a fixed version word. Software cannot address this state directly. It first writes an 8-bit index into a select register, then reads or writes the 32-bit data window, which shows whatever register the index names. Each 64-bit entry spans two consecutive index values: the even one holds the lower word and the odd one holds the upper word.

Besides storing entries, the block produces the side effects that a delivery engine next to it relies on. The remote-IRR status bit of an entry is set by that engine when it hands over a level-triggered interrupt, and a write to the entry's lower word clears it. A write that flips an entry's mask bit raises a one-cycle mask-change pulse for that pin. A write that leaves a level-triggered, unmasked entry with its request line pending raises a one-cycle redelivery pulse for that pin. The block does not deliver interrupts itself and is not a bus fabric.

Top module: `ioredir_top`

## Requirements
- R1: A write to byte offset 0x00 stores bits 7:0 of the written data in the select register. A read of offset 0x00 returns the select value zero-extended to 32 bits.
- R2: With select 0x01 the window reads (((PINS-1) & 0xFF) << 16) | VERSION, which is 0x0017_0011 by default. Writes there change nothing.
- R3: With select 0x00 a window write stores data bits 27:24 as the identifier, and the window reads the identifier in bits 27:24 with every other bit 0. Select 0x02 reads the same value, and writes there change nothing.
- R4: For select values of 0x10 and above, the entry index is (select-0x10)>>1. An even select reaches bits 31:0 of that entry and an odd select reaches bits 63:32. A write to one word leaves the other word unchanged.
- R5: When the select is between 0x03 and 0x0F, or names an index of PINS or more, the window reads 0xFFFF_FFFF and a write changes no stored state.
- R6: Bit 14 of an entry is remote-IRR. A write to the lower word stores 0 there, whatever the written data holds. A pulse on rirr_set_i[k] sets it only when bit 15 (trigger, 1 = level) of entry k is 1. A write to the upper word keeps it.
- R7: Bit 16 of an entry is the mask. A window write that changes entry k's mask bit drives mask_chg_o[k] high for exactly the cycle after the write. A write that leaves the mask unchanged raises no pulse.
- R8: A window write to entry k that leaves bit 15 set, bit 16 clear and req_lvl_i[k] sampled high in the cycle before the write drives redeliver_o[k] high for the cycle after the write. No other write raises it.
- R9: After reset the select register, the identifier and all captured request bits are 0, and every entry reads 0x0001_0000 in its lower word (mask set) and 0 in its upper word.
- R10: A read of any offset other than 0x00 and 0x10 returns 0, and a write there changes no state.
- R11: rdata_o is loaded at the clock edge where rd_en_i is high and keeps its value in every cycle where rd_en_i is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe for the current offset |
| rd_en_i | input | 1 | Read strobe; loads rdata_o |
| addr_i | input | AW (8) | Byte offset: 0x00 select, 0x10 window |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Registered read data |
| req_lvl_i | input | PINS (24) | Request level of each pin, captured every cycle |
| rirr_set_i | input | PINS (24) | Delivery engine accepted a level interrupt on pin k |
| mask_chg_o | output | PINS (24) | One-cycle pulse: entry mask bit flipped |
| redeliver_o | output | PINS (24) | One-cycle pulse: level entry with a pending request offered again |

## Verification
A read result is due one edge after the cycle that holds rd_en_i. Entry, select and identifier updates are due one edge after the write. Mask-change and redelivery pulses appear after that same edge and last one cycle. A request level counts only if it was present one cycle before the write. The bench drives every strobe on a falling edge and samples at the next falling edge, so each check sees the state exactly one edge after its stimulus. Request lines are raised two cycles before the write that depends on them.

// File: rtl/ioredir_pkg.sv
package ioredir_pkg;
  // bus offsets
  localparam int unsigned OFS_SEL = 32'h00;
  localparam int unsigned OFS_WIN = 32'h10;
  // select codes
  localparam logic [7:0] SEL_ID  = 8'h00;
  localparam logic [7:0] SEL_VER = 8'h01;
  localparam logic [7:0] SEL_ARB = 8'h02;
  localparam logic [7:0] SEL_TBL = 8'h10;
  // entry field positions decoded by neighbours
  localparam int unsigned BIT_RIRR = 14;
  localparam int unsigned BIT_TRIG = 15;
  localparam int unsigned BIT_MASK = 16;
  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;

  typedef struct packed {
    logic hit_id;
    logic hit_ver;
    logic hit_arb;
    logic hit_tbl;
    logic upper;
  } sel_kind_t;
endpackage

// File: rtl/ioredir_sel_dec.sv
module ioredir_sel_dec #(
  parameter int PINS = 24
) (
  input  logic [7:0]             sel_i,
  output ioredir_pkg::sel_kind_t kind_o,
  output logic [6:0]             idx_o
);
  import ioredir_pkg::*;
  logic [7:0] off;

  always_comb begin
    off           = sel_i - SEL_TBL;
    idx_o         = off[7:1];
    kind_o        = '0;
    kind_o.hit_id  = (sel_i == SEL_ID);
    kind_o.hit_ver = (sel_i == SEL_VER);
    kind_o.hit_arb = (sel_i == SEL_ARB);
    kind_o.hit_tbl = (sel_i >= SEL_TBL) && (32'(idx_o) < 32'(PINS));
    kind_o.upper   = sel_i[0];
  end
endmodule

// File: rtl/ioredir_entry.sv
module ioredir_entry (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_lo_i,
  input  logic        wr_hi_i,
  input  logic [31:0] wdata_i,
  input  logic        rirr_set_i,
  input  logic        pend_i,
  output logic [63:0] entry_o,
  output logic        mask_chg_o,
  output logic        redeliver_o
);
  import ioredir_pkg::*;

  logic [63:0] ent_q, ent_d;
  logic        ent_en;
  logic        mchg_d, redel_d;
  logic        wr_any;

  always_comb begin
    ent_d  = ent_q;
    wr_any = wr_lo_i | wr_hi_i;
    if (wr_lo_i) begin
      ent_d[31:0]     = wdata_i;
      ent_d[BIT_RIRR] = 1'b0;
    end else if (wr_hi_i) begin
      ent_d[63:32] = wdata_i;
    end
    if (!wr_lo_i && rirr_set_i && ent_q[BIT_TRIG]) ent_d[BIT_RIRR] = 1'b1;
    ent_en  = wr_any | rirr_set_i;
    mchg_d  = wr_any && (ent_d[BIT_MASK] != ent_q[BIT_MASK]);
    redel_d = wr_any && ent_d[BIT_TRIG] && !ent_d[BIT_MASK] && pend_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ent_q <= ENTRY_RST;
    else if (ent_en) ent_q <= ent_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_chg_o  <= 1'b0;
      redeliver_o <= 1'b0;
    end else begin
      mask_chg_o  <= mchg_d;
      redeliver_o <= redel_d;
    end
  end

  assign entry_o = ent_q;
endmodule

// File: rtl/ioredir_rdmux.sv
module ioredir_rdmux #(
  parameter int         PINS    = 24,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  ioredir_pkg::sel_kind_t   kind_i,
  input  logic [6:0]               idx_i,
  input  logic [3:0]               id_i,
  input  logic [PINS-1:0][63:0]    ents_i,
  output logic [31:0]              val_o
);
  localparam int IW = $clog2(PINS);
  localparam logic [7:0] MAXPIN = 8'(PINS - 1);

  logic [IW-1:0] idx_s;
  logic [63:0]   ent;

  always_comb begin
    idx_s = idx_i[IW-1:0];
    ent   = ents_i[idx_s];
    if (kind_i.hit_id || kind_i.hit_arb) val_o = {4'h0, id_i, 24'h0};
    else if (kind_i.hit_ver)             val_o = {8'h00, MAXPIN, 8'h00, VERSION};
    else if (kind_i.hit_tbl)             val_o = kind_i.upper ? ent[63:32] : ent[31:0];
    else                                 val_o = 32'hFFFF_FFFF;
  end
endmodule

// File: rtl/ioredir_top.sv
module ioredir_top #(
  parameter int         PINS    = 24,
  parameter int         AW      = 8,
  parameter logic [7:0] VERSION = 8'h11
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [31:0]     wdata_i,
  output logic [31:0]     rdata_o,
  input  logic [PINS-1:0] req_lvl_i,
  input  logic [PINS-1:0] rirr_set_i,
  output logic [PINS-1:0] mask_chg_o,
  output logic [PINS-1:0] redeliver_o
);
  import ioredir_pkg::*;

  localparam logic [AW-1:0] A_SEL = AW'(OFS_SEL);
  localparam logic [AW-1:0] A_WIN = AW'(OFS_WIN);

  logic [7:0]             sel_q, sel_d;
  logic [3:0]             id_q, id_d;
  logic [PINS-1:0]        pend_q;
  logic [31:0]            rdata_q, rdata_d;
  logic                   sel_en, id_en;
  logic                   wr_win;
  sel_kind_t              kind;
  logic [6:0]             idx;
  logic [31:0]            win_val;
  logic [PINS-1:0][63:0]  ents;
  logic [PINS-1:0]        wr_lo_vec, wr_hi_vec, rirr_vec;

  ioredir_sel_dec #(.PINS(PINS)) u_dec (
    .sel_i  (sel_q),
    .kind_o (kind),
    .idx_o  (idx)
  );

  // next-state for select and identifier
  always_comb begin
    wr_win = wr_en_i && (addr_i == A_WIN);
    sel_en = wr_en_i && (addr_i == A_SEL);
    sel_d  = wdata_i[7:0];
    id_en  = wr_win && kind.hit_id;
    id_d   = wdata_i[27:24];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     sel_q <= '0;
    else if (sel_en) sel_q <= sel_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    id_q <= '0;
    else if (id_en) id_q <= id_d;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pend_q <= '0;
    else         pend_q <= req_lvl_i;
  end

  for (genvar k = 0; k < PINS; k++) begin : g_ent
    assign wr_lo_vec[k] = wr_win && kind.hit_tbl && (idx == 7'(k)) && !kind.upper;
    assign wr_hi_vec[k] = wr_win && kind.hit_tbl && (idx == 7'(k)) &&  kind.upper;

    ioredir_entry u_entry (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .wr_lo_i     (wr_lo_vec[k]),
      .wr_hi_i     (wr_hi_vec[k]),
      .wdata_i     (wdata_i),
      .rirr_set_i  (rirr_set_i[k]),
      .pend_i      (pend_q[k]),
      .entry_o     (ents[k]),
      .mask_chg_o  (mask_chg_o[k]),
      .redeliver_o (redeliver_o[k])
    );
    assign rirr_vec[k] = ents[k][BIT_RIRR];
  end

  ioredir_rdmux #(.PINS(PINS), .VERSION(VERSION)) u_rdmux (
    .kind_i (kind),
    .idx_i  (idx),
    .id_i   (id_q),
    .ents_i (ents),
    .val_o  (win_val)
  );

  always_comb begin
    if (addr_i == A_SEL)      rdata_d = {24'h0, sel_q};
    else if (addr_i == A_WIN) rdata_d = win_val;
    else                      rdata_d = '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      rdata_q <= '0;
    else if (rd_en_i) rdata_q <= rdata_d;
  end

  assign rdata_o = rdata_q;
endmodule

// File: rtl/ioredir_chk.sv
module ioredir_chk #(
  parameter int PINS = 24,
  parameter int AW   = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [AW-1:0]   addr_i,
  input logic [31:0]     rdata_o,
  input logic [7:0]      sel_q,
  input logic [PINS-1:0] mask_chg_o,
  input logic [PINS-1:0] redeliver_o,
  input logic [PINS-1:0] wr_lo_vec,
  input logic [PINS-1:0] rirr_vec
);
  localparam logic [AW-1:0] A_SEL = AW'(ioredir_pkg::OFS_SEL);
  localparam logic [AW-1:0] A_WIN = AW'(ioredir_pkg::OFS_WIN);

  p_sel_hold_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && addr_i == A_SEL) |=> $stable(sel_q));

  p_rdata_hold_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |=> $stable(rdata_o));

  p_other_ofs_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i != A_SEL && addr_i != A_WIN) |=> (rdata_o == 32'h0));

  p_mask_src_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|mask_chg_o) |-> $past(wr_en_i && addr_i == A_WIN));

  p_mask_onehot_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(mask_chg_o));

  p_redel_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|redeliver_o) |-> $past(wr_en_i && addr_i == A_WIN));

  p_redel_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(redeliver_o));

  for (genvar k = 0; k < PINS; k++) begin : g_rirr
    p_rirr_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_lo_vec[k] |=> !rirr_vec[k]);
  end
endmodule

bind ioredir_top ioredir_chk #(.PINS(PINS), .AW(AW)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .wr_en_i     (wr_en_i),
  .rd_en_i     (rd_en_i),
  .addr_i      (addr_i),
  .rdata_o     (rdata_o),
  .sel_q       (sel_q),
  .mask_chg_o  (mask_chg_o),
  .redeliver_o (redeliver_o),
  .wr_lo_vec   (wr_lo_vec),
  .rirr_vec    (rirr_vec)
);

// File: tb/ioredir_top_tb_top.sv
module ioredir_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PINS = 24;
  localparam int WD_CYCLES = 100000;

  logic            clk_i = 1'b0;
  logic            rst_ni;
  logic            wr_en_i, rd_en_i;
  logic [7:0]      addr_i;
  logic [31:0]     wdata_i;
  logic [31:0]     rdata_o;
  logic [PINS-1:0] req_lvl_i, rirr_set_i, mask_chg_o, redeliver_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  ioredir_top dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .req_lvl_i(req_lvl_i), .rirr_set_i(rirr_set_i),
    .mask_chg_o(mask_chg_o), .redeliver_o(redeliver_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic bus_rd(logic [7:0] a, output logic [31:0] v);
    @(negedge clk_i);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk_i);
    rd_en_i = 1'b0;
    v = rdata_o;
  endtask

  task automatic win_rd(logic [7:0] s, output logic [31:0] v);
    bus_wr(8'h00, {24'h0, s});
    bus_rd(8'h10, v);
  endtask

  task automatic win_wr(logic [7:0] s, logic [31:0] d);
    bus_wr(8'h00, {24'h0, s});
    bus_wr(8'h10, d);
  endtask

  function automatic logic [31:0] lo_pat(int k);
    return 32'h4000 | 32'((k * 5 + 32) & 255) | 32'((k % 8) << 8);
  endfunction

  function automatic logic [31:0] hi_pat(int k);
    return 32'(k << 24) | 32'(k * 273);
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    wr_en_i = 0; rd_en_i = 0; addr_i = 0; wdata_i = 0;
    req_lvl_i = '0; rirr_set_i = '0;
    do_reset();

    // R9 reset state
    bus_rd(8'h00, v); chk("R9 select", v, 32'h0);
    win_rd(8'h00, v); chk("R9 id", v, 32'h0);
    for (int k = 0; k < PINS; k++) begin
      win_rd(8'(16 + 2*k), v);     chk("R9 entry lo", v, 32'h0001_0000);
      win_rd(8'(16 + 2*k + 1), v); chk("R9 entry hi", v, 32'h0);
    end

    // R2 version, read-only
    win_rd(8'h01, v); chk("R2 version", v, 32'(((PINS-1) & 255) << 16) | 32'h11);
    bus_wr(8'h10, 32'h1234_5678);
    bus_rd(8'h10, v); chk("R2 version after write", v, 32'h0017_0011);

    // R1 select keeps low byte
    bus_wr(8'h00, 32'hABCD_1234);
    bus_rd(8'h00, v); chk("R1 select low byte", v, 32'h34);

    // R3 identifier and arbitration alias
    win_wr(8'h00, 32'hFFFF_FFFF);
    bus_rd(8'h10, v); chk("R3 id", v, 32'h0F00_0000);
    win_rd(8'h02, v); chk("R3 arb alias", v, 32'h0F00_0000);
    bus_wr(8'h10, 32'h0);
    win_rd(8'h00, v); chk("R3 arb write ignored", v, 32'h0F00_0000);

    // R4/R6/R7 sweep of all entries
    for (int k = 0; k < PINS; k++) begin
      win_wr(8'(16 + 2*k), lo_pat(k));
      chk("R7 mask pulse", 32'(mask_chg_o), 32'(1 << k));
      @(negedge clk_i);
      chk("R7 pulse one cycle", 32'(mask_chg_o), 32'h0);
      win_wr(8'(16 + 2*k + 1), hi_pat(k));
      chk("R7 no pulse on hi", 32'(mask_chg_o), 32'h0);
    end
    for (int k = 0; k < PINS; k++) begin
      win_rd(8'(16 + 2*k), v);     chk("R4 R6 lo readback", v, lo_pat(k) & ~32'h4000);
      win_rd(8'(16 + 2*k + 1), v); chk("R4 hi readback", v, hi_pat(k));
    end
    win_wr(8'h10, lo_pat(0));
    chk("R7 same mask no pulse", 32'(mask_chg_o), 32'h0);

    // R5 out-of-range selects
    for (int s = 3; s < 256; s++) begin
      if (s < 16 || s >= 16 + 2*PINS) begin
        win_rd(8'(s), v); chk("R5 all ones", v, 32'hFFFF_FFFF);
        bus_wr(8'h10, 32'h0);
      end
    end
    for (int k = 0; k < PINS; k++) begin
      win_rd(8'(16 + 2*k), v);     chk("R5 entry lo intact", v, lo_pat(k) & ~32'h4000);
      win_rd(8'(16 + 2*k + 1), v); chk("R5 entry hi intact", v, hi_pat(k));
    end
    win_rd(8'h00, v); chk("R5 id intact", v, 32'h0F00_0000);

    // R10 other offsets
    bus_wr(8'h00, 32'h22);
    bus_rd(8'h04, v); chk("R10 ofs 04", v, 32'h0);
    bus_rd(8'h20, v); chk("R10 ofs 20", v, 32'h0);
    bus_rd(8'hFF, v); chk("R10 ofs FF", v, 32'h0);
    bus_wr(8'h20, 32'h55);
    bus_wr(8'h08, 32'h0);
    bus_rd(8'h00, v); chk("R10 write ignored", v, 32'h22);
    bus_rd(8'h10, v); chk("R10 entry intact", v, lo_pat(9) & ~32'h4000);

    // R6 remote-IRR
    win_wr(8'h16, 32'h0000_8033);           // pin 3 level, unmasked
    @(negedge clk_i); rirr_set_i[3] = 1'b1;
    @(negedge clk_i); rirr_set_i[3] = 1'b0;
    bus_rd(8'h10, v); chk("R6 rirr set level", v, 32'h0000_C033);
    win_wr(8'h17, 32'h0300_0000);
    win_rd(8'h16, v); chk("R6 rirr kept on hi write", v, 32'h0000_C033);
    bus_wr(8'h10, 32'h0000_C033);
    bus_rd(8'h10, v); chk("R6 rirr cleared on lo write", v, 32'h0000_8033);
    win_wr(8'h18, 32'h0000_0044);           // pin 4 edge
    @(negedge clk_i); rirr_set_i[4] = 1'b1;
    @(negedge clk_i); rirr_set_i[4] = 1'b0;
    bus_rd(8'h10, v); chk("R6 rirr not set edge", v, 32'h0000_0044);

    // R8 redelivery
    req_lvl_i[5] = 1'b1;
    win_wr(8'h1A, 32'h0000_8055);
    chk("R8 redeliver level pending", 32'(redeliver_o), 32'(1 << 5));
    @(negedge clk_i);
    chk("R8 pulse one cycle", 32'(redeliver_o), 32'h0);
    win_wr(8'h1A, 32'h0001_8055);
    chk("R8 masked no redeliver", 32'(redeliver_o), 32'h0);
    chk("R7 mask set pulse", 32'(mask_chg_o), 32'(1 << 5));
    win_wr(8'h1A, 32'h0000_0055);
    chk("R8 edge no redeliver", 32'(redeliver_o), 32'h0);
    win_wr(8'h1C, 32'h0000_8066);
    chk("R8 not pending no redeliver", 32'(redeliver_o), 32'h0);
    req_lvl_i = '0;

    // R11 read hold
    win_rd(8'h01, v);
    bus_wr(8'h00, 32'h02);
    repeat (3) @(negedge clk_i);
    chk("R11 rdata held", rdata_o, 32'h0017_0011);

    // R9 reset again
    do_reset();
    bus_rd(8'h00, v); chk("R9 select after reset", v, 32'h0);
    win_rd(8'h00, v); chk("R9 id after reset", v, 32'h0);
    win_rd(8'h1A, v); chk("R9 mask after reset", v, 32'h0001_0000);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule